// File: doc/BRIEF.md
# PCM Serial Clock and Framing Engine

This block is the serial side of a short-frame PCM audio port that always acts as clock master. It derives a bit clock from one of two sources: the local bus clock, or a strobe from a separate audio clock. It divides that bit clock again into a frame of programmable length. A one-bit-wide frame sync opens each frame. Inside every frame, two 16-bit transmit words go out MSB first and two 16-bit receive words are collected, one word per channel slot.

Data is launched on the falling edge of the bit clock and captured on the rising edge. Each direction has its own alignment switch. With the switch clear, the first MSB shares the bit period of the sync pulse. With it set, the first MSB comes one bit period after the sync. Transmit words arrive through a ready/valid handshake. A slot that finds no word waiting is sent as zeros and raises a one-cycle starve flag. Received words appear with a one-cycle valid strobe. FIFOs, registers and DMA belong to the surrounding logic.

Top module: `pcm_eng_top`

## Requirements
- R1: With `cfg_src_sel`=0 every clock cycle is a source tick, and `pcm_bclk` has a period of 2×(`cfg_bclk_div`+1) clock cycles, high and low for equal times.
- R2: With `cfg_src_sel`=1 only cycles with `aud_tick`=1 count as source ticks, so each half period of `pcm_bclk` lasts `cfg_bclk_div`+1 strobes.
- R3: `pcm_fsync` rises together with a falling edge of `pcm_bclk`, stays high for exactly one bit-clock period, and repeats every `cfg_frame_len`+1 bit-clock periods.
- R4: While `cfg_sclk_en`=0, `pcm_bclk`, `pcm_fsync` and `pcm_dout` are low from the next cycle on. After enabling, the first falling edge of `pcm_bclk` starts a frame, so it is the edge on which `pcm_fsync` rises.
- R5: `pcm_dout` changes only on falling edges of `pcm_bclk`. The two words of a frame are sent back to back, MSB first, starting at bit position 0 of the frame (the sync bit) when `cfg_tx_late`=0, or at position 1 when it is 1. All other positions send 0.
- R6: `tx_ready` is high for one cycle at each word start while `cfg_tx_en`=1. The word on `tx_data` is taken when `tx_valid` and `tx_ready` are both high in that cycle.
- R7: If `tx_valid` is low at a word start, that slot sends 16 zeros and `tx_starve` is high for the following cycle.
- R8: `pcm_din` is sampled on rising edges of `pcm_bclk` within the 32 slot positions, which start at position 0 (`cfg_rx_late`=0) or 1 (`cfg_rx_late`=1). The first bit received is the MSB. After the 16th bit of a word, `rx_data` holds the word and `rx_valid` is high for one cycle.
- R9: With `cfg_tx_en`=0, `tx_ready` and `tx_starve` stay low and `pcm_dout` sends 0. With `cfg_rx_en`=0, no `rx_valid` is produced. Meanwhile, the clocks keep running.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all logic is clocked here |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sclk_en | input | 1 | Runs the bit clock and frame counter; low gates them |
| cfg_src_sel | input | 1 | 0: bus clock is the source, 1: `aud_tick` strobes |
| cfg_bclk_div | input | 9 | Half period of the bit clock minus one, in source ticks |
| cfg_frame_len | input | 9 | Bit clocks per frame minus one |
| cfg_tx_en | input | 1 | Transmit direction enable |
| cfg_rx_en | input | 1 | Receive direction enable |
| cfg_tx_late | input | 1 | Transmit MSB one bit after the sync |
| cfg_rx_late | input | 1 | Receive MSB one bit after the sync |
| aud_tick | input | 1 | One-cycle strobe per audio source clock period |
| tx_data | input | 16 | Transmit word |
| tx_valid | input | 1 | `tx_data` holds a word |
| tx_ready | output | 1 | Word start; word taken when `tx_valid` is high |
| tx_starve | output | 1 | A slot started without a word |
| rx_data | output | 16 | Last received word |
| rx_valid | output | 1 | `rx_data` updated this cycle |
| pcm_bclk | output | 1 | Serial bit clock |
| pcm_fsync | output | 1 | Frame sync |
| pcm_dout | output | 1 | Serial transmit data |
| pcm_din | input | 1 | Serial receive data |

## Verification
The serial output is looped back to the input, and the bench runs a set of configurations. Within that set, the divider values differ, the frame lengths differ, and one case uses the audio strobe as its source. The received words expose the alignment. Matched transmit and receive alignment must return the sent words unchanged. Each mismatched pair must return them shifted by one bit in a known direction, which tells an off-by-one in either direction's slot window apart from a correct one. The word patterns put ones in the MSB, in the LSB and on both sides of the channel boundary, so a dropped or repeated bit shows up. Directed runs cover the gated clock, the starved slots and the disabled directions.

// File: rtl/pcm_eng_pkg.sv
package pcm_eng_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int CHAN_N    = 2;
    localparam int SLOT_BITS = SAMPLE_W * CHAN_N;
    localparam int DIV_W     = 9;
    localparam int POS_W     = 9;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [POS_W-1:0]    pos_t;

    // offset of a frame position from the first slot bit
    function automatic pos_t slot_rel(input pos_t pos, input logic late);
        return pos - pos_t'(late);
    endfunction

    function automatic logic slot_hit(input pos_t pos, input logic late);
        return (pos >= pos_t'(late)) && (slot_rel(pos, late) < pos_t'(SLOT_BITS));
    endfunction

    function automatic logic slot_first(input pos_t pos, input logic late);
        return slot_hit(pos, late) && ((slot_rel(pos, late) % pos_t'(SAMPLE_W)) == '0);
    endfunction

    function automatic logic slot_last(input pos_t pos, input logic late);
        return slot_hit(pos, late)
            && ((slot_rel(pos, late) % pos_t'(SAMPLE_W)) == pos_t'(SAMPLE_W - 1));
    endfunction

endpackage

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen
    import pcm_eng_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          src_sel,
    input  logic          aud_tick,
    input  logic [DW-1:0] half_div,
    output logic          bclk,
    output logic          launch,
    output logic          sample
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          bclk;
    } st_t;

    st_t  s_d, s_q;
    logic tick;
    logic wrap;

    always_comb begin
        tick   = src_sel ? aud_tick : 1'b1;
        wrap   = en && tick && (s_q.cnt >= half_div);
        launch = wrap && s_q.bclk;     // coming edge is a fall
        sample = wrap && !s_q.bclk;    // coming edge is a rise
        bclk   = s_q.bclk;
        s_d    = s_q;
        if (!en) begin
            s_d = '0;
        end else if (tick) begin
            if (wrap) begin
                s_d.cnt  = '0;
                s_d.bclk = ~s_q.bclk;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr
    import pcm_eng_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic launch,
    input  pos_t frame_last,
    output pos_t pos,
    output pos_t pos_next,
    output logic running,
    output logic fsync
);

    typedef struct packed {
        pos_t pos;
        logic run;
        logic fsync;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        pos_next = (!s_q.run || (s_q.pos >= frame_last)) ? '0 : s_q.pos + 1'b1;
        s_d      = s_q;
        if (!en) begin
            s_d = '0;
        end else if (launch) begin
            s_d.pos   = pos_next;
            s_d.run   = 1'b1;
            s_d.fsync = (pos_next == '0);
        end
        pos     = s_q.pos;
        running = s_q.run;
        fsync   = s_q.fsync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
    import pcm_eng_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    tx_en,
    input  logic    late,
    input  logic    launch,
    input  pos_t    pos_next,
    input  sample_t tx_data,
    input  logic    tx_valid,
    output logic    tx_ready,
    output logic    tx_starve,
    output logic    dout
);

    typedef struct packed {
        sample_t sh;
        logic    dout;
        logic    starve;
    } st_t;

    st_t  s_d, s_q;
    logic hit;
    logic first;

    always_comb begin
        hit       = slot_hit(pos_next, late);
        first     = slot_first(pos_next, late);
        tx_ready  = launch && tx_en && first;
        s_d       = s_q;
        s_d.starve = 1'b0;
        if (!en) begin
            s_d = '0;
        end else if (launch) begin
            if (!tx_en || !hit) begin
                s_d.sh   = '0;
                s_d.dout = 1'b0;
            end else begin
                if (first) begin
                    s_d.sh     = tx_valid ? tx_data : '0;
                    s_d.starve = !tx_valid;
                end else begin
                    s_d.sh = s_q.sh << 1;
                end
                s_d.dout = s_d.sh[SAMPLE_W-1];
            end
        end
        tx_starve = s_q.starve;
        dout      = s_q.dout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
    import pcm_eng_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rx_en,
    input  logic    late,
    input  logic    sample,
    input  logic    running,
    input  pos_t    pos,
    input  logic    din,
    output sample_t rx_data,
    output logic    rx_valid
);

    typedef struct packed {
        sample_t sh;
        sample_t data;
        logic    valid;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (sample && running && rx_en && slot_hit(pos, late)) begin
            s_d.sh = {s_q.sh[SAMPLE_W-2:0], din};
            if (slot_last(pos, late)) begin
                s_d.data  = s_d.sh;
                s_d.valid = 1'b1;
            end
        end
        rx_data  = s_q.data;
        rx_valid = s_q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pcm_eng_top.sv
module pcm_eng_top
    import pcm_eng_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_sclk_en,
    input  logic                cfg_src_sel,
    input  logic [DIV_W-1:0]    cfg_bclk_div,
    input  logic [POS_W-1:0]    cfg_frame_len,
    input  logic                cfg_tx_en,
    input  logic                cfg_rx_en,
    input  logic                cfg_tx_late,
    input  logic                cfg_rx_late,
    input  logic                aud_tick,
    input  logic [SAMPLE_W-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                tx_starve,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid,
    output logic                pcm_bclk,
    output logic                pcm_fsync,
    output logic                pcm_dout,
    input  logic                pcm_din
);

    logic launch;
    logic sample;
    logic running;
    pos_t pos;
    pos_t pos_next;

    pcm_bclk_gen #(.DW(DIV_W)) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_sclk_en),
        .src_sel  (cfg_src_sel),
        .aud_tick (aud_tick),
        .half_div (cfg_bclk_div),
        .bclk     (pcm_bclk),
        .launch   (launch),
        .sample   (sample)
    );

    pcm_frame_ctr u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_sclk_en),
        .launch     (launch),
        .frame_last (cfg_frame_len),
        .pos        (pos),
        .pos_next   (pos_next),
        .running    (running),
        .fsync      (pcm_fsync)
    );

    pcm_tx_ser u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_sclk_en),
        .tx_en     (cfg_tx_en),
        .late      (cfg_tx_late),
        .launch    (launch),
        .pos_next  (pos_next),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_starve (tx_starve),
        .dout      (pcm_dout)
    );

    pcm_rx_deser u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (cfg_rx_en),
        .late     (cfg_rx_late),
        .sample   (sample),
        .running  (running),
        .pos      (pos),
        .din      (pcm_din),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/pcm_eng_chk.sv
module pcm_eng_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_sclk_en,
    input logic cfg_tx_en,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_starve,
    input logic rx_valid,
    input logic pcm_bclk,
    input logic pcm_fsync,
    input logic pcm_dout
);

    assert_fsync_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcm_fsync) |-> $fell(pcm_bclk));

    assert_gated_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sclk_en |=> (!pcm_bclk && !pcm_fsync && !pcm_dout));

    assert_dout_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pcm_dout) && $past(cfg_sclk_en)) |-> $fell(pcm_bclk));

    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    assert_starve_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> tx_starve);

    assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_no_ready_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx_en |-> !tx_ready);

endmodule

bind pcm_eng_top pcm_eng_chk u_chk (.*);

// File: tb/tb_pcm_eng_top.sv
`timescale 1ns/1ps
module tb_pcm_eng_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sclk_en = 1'b0, cfg_src_sel = 1'b0;
    logic [8:0]  cfg_bclk_div = '0, cfg_frame_len = 9'd39;
    logic        cfg_tx_en = 1'b0, cfg_rx_en = 1'b0, cfg_tx_late = 1'b0, cfg_rx_late = 1'b0;
    logic        aud_tick = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, tx_starve, rx_valid, pcm_bclk, pcm_fsync, pcm_dout, pcm_din;
    logic [15:0] rx_data;

    assign pcm_din = pcm_dout;   // loopback

    always #2 clk = ~clk;

    pcm_eng_top dut (.*);

    int tdiv = 0;
    always @(posedge clk) begin
        tdiv     <= (tdiv == 2) ? 0 : tdiv + 1;
        aud_tick <= (tdiv == 2);
    end

    // ---------------- monitor ----------------
    logic mon_clr = 1'b0;
    int cyc, last_br, last_fr, bper, fper, fwid, fs_rises, rx_n, ready_n, starve_n;
    int dout_ones, bclk_hi, pre_falls, fs_misalign;
    logic bclk_p, fs_p, dout_at_fs;
    logic [15:0] rx_buf [8];

    always @(negedge clk) begin
        if (mon_clr) begin
            cyc = 0; last_br = -1; last_fr = -1; bper = 0; fper = 0; fwid = 0;
            fs_rises = 0; rx_n = 0; ready_n = 0; starve_n = 0; dout_ones = 0;
            bclk_hi = 0; pre_falls = 0; fs_misalign = 0; dout_at_fs = 1'b0;
            bclk_p = pcm_bclk; fs_p = pcm_fsync;
        end else begin
            cyc++;
            if (pcm_bclk) bclk_hi++;
            if (pcm_dout) dout_ones++;
            if (pcm_bclk && !bclk_p) begin
                if (last_br >= 0) bper = cyc - last_br;
                last_br = cyc;
            end
            if (!pcm_bclk && bclk_p && !(pcm_fsync && !fs_p) && fs_rises == 0) pre_falls++;
            if (pcm_fsync && !fs_p) begin
                if (!(!pcm_bclk && bclk_p)) fs_misalign++;
                if (fs_rises == 0) dout_at_fs = pcm_dout;
                if (last_fr >= 0) fper = cyc - last_fr;
                last_fr = cyc;
                fs_rises++;
            end
            if (!pcm_fsync && fs_p) fwid = cyc - last_fr;
            if (rx_valid) begin
                if (rx_n < 8) rx_buf[rx_n] = rx_data;
                rx_n++;
            end
            if (tx_ready) ready_n++;
            if (tx_starve) starve_n++;
            bclk_p = pcm_bclk; fs_p = pcm_fsync;
        end
    end

    // ---------------- bookkeeping ----------------
    int tests = 0, fails = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mon_reset();
        mon_clr = 1'b1;
        @(negedge clk);
        #1 mon_clr = 1'b0;
    endtask

    task automatic wait_fs(input int n);
        while (fs_rises < n) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_rx(input logic tl, input logic rl,
                                           input logic [15:0] w0, input logic [15:0] w1,
                                           input int idx);
        logic [31:0] st;
        logic [31:0] pr;
        st = {w0, w1};
        if (tl == rl)     pr = st;
        else if (tl)      pr = {1'b0, st[31:1]};
        else              pr = {st[30:0], 1'b0};
        return (idx == 0) ? pr[31:16] : pr[15:0];
    endfunction

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [8:0]  div;
        logic [8:0]  flen;
        logic        src;
        logic        tl;
        logic        rl;
        logic [15:0] w0;
        logic [15:0] w1;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{9'd0, 9'd39, 1'b0, 1'b0, 1'b0, 16'hA5C3, 16'h1E87},
        '{9'd1, 9'd39, 1'b0, 1'b1, 1'b1, 16'h8001, 16'h7FFE},
        '{9'd0, 9'd47, 1'b0, 1'b1, 1'b0, 16'hC0DE, 16'h1235},
        '{9'd2, 9'd35, 1'b0, 1'b0, 1'b1, 16'hBEEF, 16'hF00D},
        '{9'd0, 9'd39, 1'b1, 1'b0, 1'b0, 16'h5A5A, 16'h0FF1},
        '{9'd3, 9'd63, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h0001}
    };

    task automatic configure(input vec_t v, input logic txe, input logic rxe);
        cfg_sclk_en = 1'b0;
        @(negedge clk); @(negedge clk);
        cfg_bclk_div = v.div; cfg_frame_len = v.flen; cfg_src_sel = v.src;
        cfg_tx_late = v.tl; cfg_rx_late = v.rl; cfg_tx_en = txe; cfg_rx_en = rxe;
        mon_reset();
    endtask

    task automatic run_vec(input vec_t v);
        int exp_bper;
        configure(v, 1'b1, 1'b1);
        tx_data = v.w0; tx_valid = 1'b1;
        cfg_sclk_en = 1'b1;
        do @(negedge clk); while (!tx_ready);
        @(posedge clk); #1 tx_data = v.w1;
        @(negedge clk);
        check(!tx_ready, "R6 ready one cycle", tx_ready, 0);
        do @(negedge clk); while (!tx_ready);
        @(posedge clk); #1 tx_valid = 1'b0;
        wait_fs(2);
        while (rx_n < 2) @(negedge clk);
        exp_bper = 2 * (v.div + 1) * (v.src ? 3 : 1);
        check(rx_buf[0] == exp_rx(v.tl, v.rl, v.w0, v.w1, 0), "R8/R5 rx word0",
              rx_buf[0], exp_rx(v.tl, v.rl, v.w0, v.w1, 0));
        check(rx_buf[1] == exp_rx(v.tl, v.rl, v.w0, v.w1, 1), "R8/R5 rx word1",
              rx_buf[1], exp_rx(v.tl, v.rl, v.w0, v.w1, 1));
        check(bper == exp_bper, v.src ? "R2 bclk period" : "R1 bclk period", bper, exp_bper);
        check(fper == (v.flen + 1) * exp_bper, "R3 frame period", fper, (v.flen + 1) * exp_bper);
        check(fwid == exp_bper, "R3 fsync width", fwid, exp_bper);
        check(fs_misalign == 0, "R3 fsync on bclk fall", fs_misalign, 0);
        check(dout_at_fs == (v.tl ? 1'b0 : v.w0[15]), "R5 MSB alignment",
              dout_at_fs, v.tl ? 1'b0 : v.w0[15]);
    endtask

    // ---------------- main ----------------
    initial begin
        vec_t d;
        repeat (3) @(negedge clk);
        check(!pcm_bclk && !pcm_fsync && !pcm_dout && !tx_ready && !tx_starve && !rx_valid
              && rx_data == 16'h0, "R10 reset outputs", {pcm_bclk, pcm_fsync, pcm_dout}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pcm_bclk && !pcm_fsync && !rx_valid, "R10 idle after reset", pcm_bclk, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R4: gated clock stays low, then first fall opens a frame
        d = '{9'd1, 9'd39, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0};
        configure(d, 1'b1, 1'b1);
        repeat (40) @(negedge clk);
        check(bclk_hi == 0 && fs_rises == 0 && dout_ones == 0, "R4 gated outputs low",
              bclk_hi + fs_rises, 0);
        cfg_sclk_en = 1'b1;
        wait_fs(1);
        check(pre_falls == 0, "R4 first fall starts frame", pre_falls, 0);
        check(fs_misalign == 0, "R4 fsync with first fall", fs_misalign, 0);

        // R7: starved slots send zeros
        d = '{9'd0, 9'd39, 1'b0, 1'b1, 1'b1, 16'h0, 16'h0};
        configure(d, 1'b1, 1'b1);
        tx_valid = 1'b0; tx_data = 16'hFFFF;
        cfg_sclk_en = 1'b1;
        wait_fs(3);
        check(starve_n == 4, "R7 starve pulses", starve_n, 4);
        check(ready_n == 4, "R6 ready per word start", ready_n, 4);
        check(dout_ones == 0, "R7 zeros sent", dout_ones, 0);
        check(rx_n == 4 && rx_buf[0] == 16'h0 && rx_buf[3] == 16'h0, "R7 zero words looped",
              rx_buf[0], 0);

        // R9: both directions off, clocks still run
        d = '{9'd0, 9'd39, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0};
        configure(d, 1'b0, 1'b0);
        tx_valid = 1'b1; tx_data = 16'hFFFF;
        cfg_sclk_en = 1'b1;
        wait_fs(3);
        check(ready_n == 0 && starve_n == 0, "R9 no tx handshake", ready_n + starve_n, 0);
        check(dout_ones == 0, "R9 dout low", dout_ones, 0);
        check(rx_n == 0, "R9 no rx_valid", rx_n, 0);
        check(bper == 2, "R9 clocks running", bper, 2);
        tx_valid = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog (all requirements) actual=hang expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule